// File: doc/BRIEF.md
# Strobe-and-Clock Converter Host Controller

This block is the host-side master for a serial analog-to-digital converter that is driven by an active-low conversion strobe and a serial clock. The strobe falls to open a frame. The serial clock runs at the system clock divided by a programmable ratio. The returned 12-bit word is shifted in MSB first on the rising edges of the serial clock. Each captured word is then offered on a valid/ready output stream. It is either zero-extended or sign-extended to the output width, as configured.

Besides single conversions, the controller can run frames back to back while a level input stays high. It can also put the converter into a partial or full power-down state and wake it again. It keeps its own record of the converter's power state. A request for full power-down from the normal state therefore becomes two partial power-down sequences, while the same request from the partial state needs only one. Each request is carried out as a timed strobe pattern with a set number of clock edges.

Back-pressure on the output stream: a captured word stays in `smp_data` with `smp_valid` high until a cycle with `smp_ready` high. No new frame of any kind starts while a word is waiting. The converter is therefore never clocked while its previous result is still unread.

Top module: `cnv_host_ctrl`

## Requirements
- R1: Reset state: `cnv_n` high, `sclk` low, `busy` low, `smp_valid` low, `pwr_mode` 0 and `cmd_ready` high, with `run_cont` low.
- R2: A command is taken on a cycle with `cmd_valid` and `cmd_ready` both high. `cmd_op` is coded 0 = convert, 1 = partial power-down, 2 = full power-down, 3 = wake. `cmd_ready` is high only when no sequence is running, no sample is pending and `run_cont` is low. `busy` rises in the same cycle that `cnv_n` falls and stays high until the sequence ends.
- R3: The serial clock idles low. Each half period lasts `clk_div`+1 system clocks, with `clk_div` latched when a sequence starts. The first rising edge comes one half period after `cnv_n` falls.
- R4: A single conversion produces exactly 16 rising edges of `sclk`. `cnv_n` stays low until the falling edge that follows the 16th rising edge, and it rises in that same cycle.
- R5: `sdata` is sampled in the system cycle in which `sclk` rises. The bits taken at rising edges 1 to 4 are dropped, and the bits taken at edges 5 to 16 form data bits 11 down to 0.
- R6: With `signed_mode` 0, bits 15..12 of `smp_data` are zero. With `signed_mode` 1, those bits are copies of data bit 11.
- R7: While `smp_valid` is high and `smp_ready` is low, `smp_valid` and `smp_data` hold. No new frame starts until the word has been taken.
- R8: While `run_cont` is high and `pwr_mode` is 0, frames start back to back. Each frame has 16 rising edges, and `cnv_n` rises at the falling edge after the 14th. `run_cont` has no effect in either power-down state.
- R9: A partial power-down sequence raises `cnv_n` at the falling edge after the 8th rising edge and generates no further `sclk` edges. At its end `pwr_mode` moves from 0 (normal) to 1 (partial).
- R10: Full power-down from state 0 runs two partial sequences of 8 edges each, separated by a strobe-high gap of one half period. From state 1 it runs one such sequence. Either way `pwr_mode` ends at 2 (full).
- R11: Wake from state 1 or 2 holds `cnv_n` low for 16 rising edges and raises it after the 16th. It raises no `smp_valid` for the data of that frame, and it sets `pwr_mode` to 0.
- R12: A command that does not apply is taken and does nothing: `cnv_n` does not fall, and both `pwr_mode` and the output stream stay unchanged. The cases are convert while powered down, partial power-down while powered down, full power-down while in state 2, and wake while in state 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clk_div | input | 8 | Half-period of `sclk` minus one, in system clocks |
| signed_mode | input | 1 | 1: sign-extend the captured word |
| run_cont | input | 1 | Level request for back-to-back conversions |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | Command code |
| smp_valid | output | 1 | Captured sample available |
| smp_ready | input | 1 | Consumer takes the sample |
| smp_data | output | 16 | Formatted sample |
| busy | output | 1 | A strobe sequence is in progress |
| pwr_mode | output | 2 | Tracked converter power state |
| cnv_n | output | 1 | Conversion strobe to the converter, active low |
| sclk | output | 1 | Serial clock to the converter |
| sdata | input | 1 | Serial data from the converter |

## Verification
The end of a conversion frame and the drain of the output stream can fall on the same edge. The end of a frame also competes with the back-to-back restart requested by `run_cont`. The bench holds `smp_ready` low while continuous mode is active, so a finished frame leaves a word waiting. It checks that the strobe does not fall again while the word waits. It then releases `smp_ready` and checks that frames resume, with every word taken exactly once and carrying the expected value.

// File: rtl/cnv_host_pkg.sv
package cnv_host_pkg;
  typedef enum logic [1:0] {
    OP_CONV = 2'd0,
    OP_PPD  = 2'd1,
    OP_FPD  = 2'd2,
    OP_WAKE = 2'd3
  } op_e;

  typedef enum logic [1:0] {
    PM_NORMAL  = 2'd0,
    PM_PARTIAL = 2'd1,
    PM_FULL    = 2'd2
  } pmode_e;

  typedef enum logic [1:0] {
    FR_SINGLE,
    FR_CONT,
    FR_PD,
    FR_WAKE
  } frame_e;

  typedef enum logic [1:0] {
    S_IDLE,
    S_CLK,
    S_GAP
  } seq_state_e;
endpackage

// File: rtl/cnv_sclk_div.sv
module cnv_sclk_div #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [DIV_W-1:0] div_val,
  input  logic             run,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt   <= '0;
    end else if (load) begin
      div_q <= div_val;
      cnt   <= '0;
    end else if (run) begin
      if (cnt == div_q) cnt <= '0;
      else              cnt <= cnt + 1'b1;
    end
  end

  assign tick = run && (cnt == div_q);

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= div_q);
endmodule

// File: rtl/cnv_frame_seq.sv
module cnv_frame_seq
  import cnv_host_pkg::*;
#(
  parameter int FRAME_EDGES = 16,
  parameter int CONT_EDGE   = 14,
  parameter int PD_EDGE     = 8
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_valid,
  input  logic [1:0] cmd_op,
  output logic       cmd_ready,
  input  logic       run_cont,
  input  logic       out_pending,
  input  logic       tick,
  output logic       div_load,
  output logic       run,
  output logic       shift_en,
  output logic       capture,
  output logic       busy,
  output logic [1:0] pwr_mode,
  output logic       cnv_n,
  output logic       sclk
);
  localparam int EDGE_W = $clog2(FRAME_EDGES + 1);
  localparam logic [EDGE_W-1:0] FRAME_E = EDGE_W'(FRAME_EDGES);
  localparam logic [EDGE_W-1:0] CONT_E  = EDGE_W'(CONT_EDGE);
  localparam logic [EDGE_W-1:0] PD_E    = EDGE_W'(PD_EDGE);

  seq_state_e        st;
  frame_e            kind;
  pmode_e            pmode;
  logic [EDGE_W-1:0] edge_cnt;
  logic              pd_more;
  logic              cnv_q, sclk_q;

  logic   go, go_more, cont_go;
  frame_e go_kind;

  assign cmd_ready = (st == S_IDLE) && !out_pending && !run_cont;
  assign cont_go   = (st == S_IDLE) && !out_pending && run_cont && (pmode == PM_NORMAL);

  always_comb begin
    go      = 1'b0;
    go_kind = FR_SINGLE;
    go_more = 1'b0;
    if (cmd_valid && cmd_ready) begin
      case (cmd_op)
        OP_CONV: go = (pmode == PM_NORMAL);
        OP_PPD: begin
          go      = (pmode == PM_NORMAL);
          go_kind = FR_PD;
        end
        OP_FPD: begin
          go      = (pmode != PM_FULL);
          go_kind = FR_PD;
          go_more = (pmode == PM_NORMAL);
        end
        default: begin
          go      = (pmode != PM_NORMAL);
          go_kind = FR_WAKE;
        end
      endcase
    end else if (cont_go) begin
      go      = 1'b1;
      go_kind = FR_CONT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      kind     <= FR_SINGLE;
      pmode    <= PM_NORMAL;
      edge_cnt <= '0;
      pd_more  <= 1'b0;
      cnv_q    <= 1'b1;
      sclk_q   <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (go) begin
          st       <= S_CLK;
          kind     <= go_kind;
          pd_more  <= go_more;
          edge_cnt <= '0;
          cnv_q    <= 1'b0;
          sclk_q   <= 1'b0;
        end
        S_CLK: if (tick) begin
          if (!sclk_q) begin
            sclk_q   <= 1'b1;
            edge_cnt <= edge_cnt + 1'b1;
          end else begin
            sclk_q <= 1'b0;
            if (kind == FR_PD && edge_cnt == PD_E) begin
              cnv_q <= 1'b1;
              pmode <= (pmode == PM_NORMAL) ? PM_PARTIAL : PM_FULL;
              if (pd_more) begin
                pd_more <= 1'b0;
                st      <= S_GAP;
              end else begin
                st <= S_IDLE;
              end
            end else if (edge_cnt == FRAME_E) begin
              cnv_q <= 1'b1;
              st    <= S_IDLE;
              if (kind == FR_WAKE) pmode <= PM_NORMAL;
            end else if (kind == FR_CONT && edge_cnt == CONT_E) begin
              cnv_q <= 1'b1;
            end
          end
        end
        S_GAP: if (tick) begin
          cnv_q    <= 1'b0;
          edge_cnt <= '0;
          st       <= S_CLK;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign div_load = (st == S_IDLE) && go;
  assign run      = (st != S_IDLE);
  assign shift_en = (st == S_CLK) && tick && !sclk_q;
  assign capture  = (st == S_CLK) && tick && sclk_q && (edge_cnt == FRAME_E) &&
                    ((kind == FR_SINGLE) || (kind == FR_CONT));
  assign busy     = (st != S_IDLE);
  assign pwr_mode = pmode;
  assign cnv_n    = cnv_q;
  assign sclk     = sclk_q;

  // R2
  strobe_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cnv_n |-> busy);
  // R3
  sclk_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !sclk);
  // R4
  edge_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    edge_cnt <= FRAME_E);
  // R9
  pd_edge_cut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_CLK && kind == FR_PD) |-> edge_cnt <= PD_E);
  // R12
  mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy) |-> $stable(pwr_mode));
endmodule

// File: rtl/cnv_sample_out.sv
module cnv_sample_out #(
  parameter int DATA_W = 12,
  parameter int OUT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             sdata,
  input  logic             capture,
  input  logic             signed_mode,
  input  logic             smp_ready,
  output logic             smp_valid,
  output logic [OUT_W-1:0] smp_data
);
  logic [DATA_W-1:0] sh;
  logic [OUT_W-1:0]  ext;

  always_ff @(posedge clk) begin
    if (!rst_n)        sh <= '0;
    else if (shift_en) sh <= {sh[DATA_W-2:0], sdata};
  end

  generate
    if (OUT_W > DATA_W) begin : g_ext
      assign ext = {{(OUT_W-DATA_W){signed_mode & sh[DATA_W-1]}}, sh};
    end else begin : g_same
      assign ext = sh;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_valid <= 1'b0;
      smp_data  <= '0;
    end else if (capture) begin
      smp_valid <= 1'b1;
      smp_data  <= ext;
    end else if (smp_valid && smp_ready) begin
      smp_valid <= 1'b0;
    end
  end

  // R7
  hold_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_valid && !smp_ready) |=> (smp_valid && $stable(smp_data)));
  // R7
  capture_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    capture |-> !smp_valid);
endmodule

// File: rtl/cnv_host_ctrl.sv
module cnv_host_ctrl #(
  parameter int DIV_W       = 8,
  parameter int DATA_W      = 12,
  parameter int OUT_W       = 16,
  parameter int FRAME_EDGES = 16,
  parameter int CONT_EDGE   = 14,
  parameter int PD_EDGE     = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DIV_W-1:0] clk_div,
  input  logic             signed_mode,
  input  logic             run_cont,
  input  logic             cmd_valid,
  output logic             cmd_ready,
  input  logic [1:0]       cmd_op,
  output logic             smp_valid,
  input  logic             smp_ready,
  output logic [OUT_W-1:0] smp_data,
  output logic             busy,
  output logic [1:0]       pwr_mode,
  output logic             cnv_n,
  output logic             sclk,
  input  logic             sdata
);
  logic tick, div_load, run, shift_en, capture;

  cnv_sclk_div #(.DIV_W(DIV_W)) u_div (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (div_load),
    .div_val (clk_div),
    .run     (run),
    .tick    (tick)
  );

  cnv_frame_seq #(
    .FRAME_EDGES (FRAME_EDGES),
    .CONT_EDGE   (CONT_EDGE),
    .PD_EDGE     (PD_EDGE)
  ) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_op      (cmd_op),
    .cmd_ready   (cmd_ready),
    .run_cont    (run_cont),
    .out_pending (smp_valid),
    .tick        (tick),
    .div_load    (div_load),
    .run         (run),
    .shift_en    (shift_en),
    .capture     (capture),
    .busy        (busy),
    .pwr_mode    (pwr_mode),
    .cnv_n       (cnv_n),
    .sclk        (sclk)
  );

  cnv_sample_out #(.DATA_W(DATA_W), .OUT_W(OUT_W)) u_out (
    .clk         (clk),
    .rst_n       (rst_n),
    .shift_en    (shift_en),
    .sdata       (sdata),
    .capture     (capture),
    .signed_mode (signed_mode),
    .smp_ready   (smp_ready),
    .smp_valid   (smp_valid),
    .smp_data    (smp_data)
  );
endmodule

// File: tb/tb_cnv_host_ctrl.sv
`timescale 1ns/1ps
module tb_cnv_host_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  clk_div = 8'd1;
  logic        signed_mode = 1'b0;
  logic        run_cont = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [1:0]  cmd_op = 2'd0;
  logic        smp_valid;
  logic        smp_ready = 1'b1;
  logic [15:0] smp_data;
  logic        busy;
  logic [1:0]  pwr_mode;
  logic        cnv_n;
  logic        sclk;
  logic        sdata = 1'b0;

  cnv_host_ctrl dut (
    .clk(clk), .rst_n(rst_n), .clk_div(clk_div), .signed_mode(signed_mode),
    .run_cont(run_cont), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .smp_valid(smp_valid), .smp_ready(smp_ready),
    .smp_data(smp_data), .busy(busy), .pwr_mode(pwr_mode), .cnv_n(cnv_n),
    .sclk(sclk), .sdata(sdata)
  );

  always #2.5 clk = ~clk;

  int tests = 0, fails = 0;
  bit done = 0;
  int wd = 0;

  // converter model and observers
  logic [11:0] adc_word = 12'h000;
  logic [15:0] exp_data = 16'h0000;
  logic        prev_cnv = 1'b1, prev_sclk = 1'b0;
  int falls = 0, edges = 0, tot_edges = 0, rise_at = 0, cyc = 0, first_rise = 0;
  int vcount = 0, bad_data = 0;
  logic [15:0] last_data = 16'h0;

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_cnv  = 1'b1;
      prev_sclk = 1'b0;
    end else begin
      if (prev_cnv && !cnv_n) begin
        falls++; edges = 0; cyc = 0;
      end else cyc++;
      if (!prev_sclk && sclk) begin
        if (edges == 0) first_rise = cyc;
        edges++; tot_edges++;
      end
      if (!prev_cnv && cnv_n) rise_at = edges;
      if (smp_valid && smp_ready) begin
        vcount++; last_data = smp_data;
        if (smp_data !== exp_data) bad_data++;
      end
      prev_cnv  = cnv_n;
      prev_sclk = sclk;
    end
    begin
      int nxt;
      nxt = edges + 1;
      sdata = (nxt >= 5 && nxt <= 16) ? adc_word[16-nxt] : 1'b0;
    end
  end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000 && !done) begin
      done = 1;
      tests++; fails++;
      $display("FAIL watchdog act=%0d exp=<150000", wd);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] op);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  // {clk_div, signed_mode, word, expected}
  localparam logic [36:0] VEC [6] = '{
    {8'd0, 1'b0, 12'hABC, 16'h0ABC},
    {8'd1, 1'b1, 12'hABC, 16'hFABC},
    {8'd3, 1'b1, 12'h7FF, 16'h07FF},
    {8'd2, 1'b0, 12'hFFF, 16'h0FFF},
    {8'd1, 1'b1, 12'h800, 16'hF800},
    {8'd5, 1'b0, 12'h001, 16'h0001}
  };

  initial begin
    int f0, v0, e0, b0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 cnv_n", cnv_n, 1); chk("R1 sclk", sclk, 0); chk("R1 busy", busy, 0);
    chk("R1 smp_valid", smp_valid, 0); chk("R1 pwr_mode", pwr_mode, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 cmd_ready", cmd_ready, 1);

    // table walk: single conversions (R3 R4 R5 R6)
    for (int i = 0; i < 6; i++) begin
      clk_div = VEC[i][36:29]; signed_mode = VEC[i][28];
      adc_word = VEC[i][27:16]; exp_data = VEC[i][15:0];
      v0 = vcount;
      send(2'd0);
      wait_idle();
      chk("R5 R6 sample", last_data, VEC[i][15:0]);
      chk("R7 one word", vcount - v0, 1);
      chk("R4 edges", edges, 16);
      chk("R4 strobe rise", rise_at, 16);
      chk("R3 half period", first_rise, VEC[i][36:29] + 1);
    end

    // R2 busy with strobe, cmd_ready low
    clk_div = 8'd2; adc_word = 12'h123; exp_data = 16'h0123; signed_mode = 1'b0;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'd0;
    @(negedge clk); cmd_valid = 1'b0;
    chk("R2 busy", busy, 1); chk("R2 strobe", cnv_n, 0); chk("R2 ready low", cmd_ready, 0);
    wait_idle();

    // R7 back-pressure on single conversion
    smp_ready = 1'b0; adc_word = 12'h3C5; exp_data = 16'h03C5; v0 = vcount;
    send(2'd0);
    wait_idle();
    chk("R7 valid held", smp_valid, 1);
    chk("R7 ready blocked", cmd_ready, 0);
    repeat (10) @(negedge clk);
    chk("R7 data held", smp_data, 16'h03C5);
    smp_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk("R7 drained", vcount - v0, 1);

    // R8 continuous
    adc_word = 12'h5A3; exp_data = 16'h05A3; clk_div = 8'd1;
    v0 = vcount; f0 = falls; e0 = tot_edges; b0 = bad_data;
    run_cont = 1'b1;
    @(negedge clk);
    chk("R2 ready low in cont", cmd_ready, 0);
    while (vcount - v0 < 3) @(negedge clk);
    run_cont = 1'b0;
    wait_idle();
    chk("R8 edges per frame", tot_edges - e0, 16 * (falls - f0));
    chk("R8 strobe rise at 14", rise_at, 14);
    chk("R8 all words", vcount - v0, falls - f0);
    chk("R8 data", bad_data - b0, 0);

    // continuous under back-pressure (R7 R8)
    smp_ready = 1'b0; v0 = vcount; f0 = falls; b0 = bad_data;
    run_cont = 1'b1;
    repeat (300) @(negedge clk);
    chk("R7 stalled frames", falls - f0, 1);
    chk("R7 stalled valid", smp_valid, 1);
    smp_ready = 1'b1;
    repeat (200) @(negedge clk);
    run_cont = 1'b0;
    wait_idle();
    chk("R7 resumed", (falls - f0) > 1, 1);
    chk("R7 no loss", vcount - v0, falls - f0);
    chk("R7 data", bad_data - b0, 0);

    // R9 partial power-down
    v0 = vcount; f0 = falls;
    send(2'd1);
    wait_idle();
    repeat (20) @(negedge clk);
    chk("R9 one sequence", falls - f0, 1);
    chk("R9 strobe at 8", rise_at, 8);
    chk("R9 no more clocks", edges, 8);
    chk("R9 mode", pwr_mode, 1);
    chk("R9 no word", vcount - v0, 0);

    // R12 convert / partial while partial; R8 run_cont ignored
    f0 = falls;
    send(2'd0); send(2'd1);
    run_cont = 1'b1;
    repeat (60) @(negedge clk);
    chk("R8 no frames powered down", falls - f0, 0);
    run_cont = 1'b0;
    repeat (5) @(negedge clk);
    chk("R12 no strobe", falls - f0, 0);
    chk("R12 mode kept", pwr_mode, 1);
    chk("R12 no word", vcount - v0, 0);

    // R10 full from partial
    e0 = tot_edges; f0 = falls;
    send(2'd2);
    wait_idle();
    chk("R10 one sequence", falls - f0, 1);
    chk("R10 edges", tot_edges - e0, 8);
    chk("R10 mode full", pwr_mode, 2);

    // R12 full while full
    f0 = falls;
    send(2'd2); send(2'd1);
    repeat (20) @(negedge clk);
    chk("R12 full no strobe", falls - f0, 0);
    chk("R12 full kept", pwr_mode, 2);

    // R11 wake
    f0 = falls; v0 = vcount;
    send(2'd3);
    wait_idle();
    chk("R11 one frame", falls - f0, 1);
    chk("R11 edges", edges, 16);
    chk("R11 strobe at 16", rise_at, 16);
    chk("R11 no word", vcount - v0, 0);
    chk("R11 mode normal", pwr_mode, 0);

    // R12 wake while normal
    f0 = falls;
    send(2'd3);
    repeat (20) @(negedge clk);
    chk("R12 wake no strobe", falls - f0, 0);

    // R10 full from normal
    f0 = falls; e0 = tot_edges;
    send(2'd2);
    wait_idle();
    chk("R10 two sequences", falls - f0, 2);
    chk("R10 edges twice", tot_edges - e0, 16);
    chk("R10 last at 8", rise_at, 8);
    chk("R10 mode", pwr_mode, 2);

    // wake and convert again after power-down
    send(2'd3); wait_idle();
    adc_word = 12'h9E1; exp_data = 16'hF9E1; signed_mode = 1'b1;
    send(2'd0); wait_idle();
    chk("R6 after wake", last_data, 16'hF9E1);

    // R1 reset in the middle of a frame
    clk_div = 8'd4;
    @(negedge clk); cmd_valid = 1'b1; cmd_op = 2'd0;
    @(negedge clk); cmd_valid = 1'b0;
    repeat (12) @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R1 mid cnv_n", cnv_n, 1); chk("R1 mid sclk", sclk, 0);
    chk("R1 mid busy", busy, 0); chk("R1 mid valid", smp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mid ready", cmd_ready, 1);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule